// File: doc/BRIEF.md
# Dual-Converter Trigger and Start Controller

This block decides when each of two analog-to-digital converter units begins a conversion. Each unit has a start bit, a 3-bit channel field, a 2-bit run mode and a 4-bit trigger-select field. A unit can be started by software, by the rising edge of an external trigger pin, or by the rising edge of either of two timer request lines. A shared dual-start pulse launches both units together, so that their inputs are sampled in the same cycle.

Once a unit is started, it waits for the next tick of a divided conversion clock enable, adds a fixed start latency, opens a sampling window and then hands over to the converter core. The core reports back through a per-unit done input. In multi mode the unit walks channels 0 up to its channel field. In scan mode it repeats that walk until software halts it. Only the first conversion of a run carries the aligned start delay; later ones wait a short fixed gap. Clearing a unit's start bit is the only way to stop a running conversion.

Top module: `adc_dual_start`

## Requirements
- R1: During and after reset, with no start request, busy, smp_win, conv_go and done are all low for both units.
- R2: The trigger-select code chooses a unit's hardware start source: 1 is ext_trg, 2 is tmr_a_trg, 3 is tmr_b_trg, and 0 or 4 to 15 is none. A rising edge on the selected source while the unit is idle sets busy in the next cycle. A software start does the same.
- R3: After busy rises, the unit waits through cycles until it reaches a cycle with conv_ce high. It then waits START_LAT more cycles before smp_win rises. The delay is the same for a software start and a hardware start.
- R4: smp_win stays high for SMP_CYC cycles. conv_go is high only in the last cycle of the window, and smp_win is low in the cycle after it.
- R5: When both units select the same hardware source, one edge starts both units in the same cycle, and both sample in the same cycle. Each unit converts the channel in its own channel field.
- R6: A dual_start pulse while both units are idle starts both units together, with smp_win rising in the same cycle on both. If either unit is busy, the pulse is ignored and does not disturb the running conversion.
- R7: sw_halt stops the unit at once: busy and smp_win are low in the next cycle, and no done pulse follows. Halt takes priority over any start in the same cycle.
- R8: In single mode (run_mode 0, and also 3), cur_ch equals the channel field at conv_go. A conv_done input ends the run: busy is low in the next cycle and done is high for exactly that one cycle.
- R9: In multi mode (run_mode 1), the unit converts channels 0 up to its channel field in ascending order. After each conv_done other than the last, it waits NEXT_CYC cycles and then reopens the window with no conv_ce alignment. Done is raised after the last conversion.
- R10: In scan mode (run_mode 2), the channel sequence repeats from 0 after the last channel. Busy stays high and no done pulse is raised until the unit is halted.
- R11: Triggers are edge-detected. A source held high starts at most one run. An edge that arrives while the unit is busy is dropped and does not cause a later start.
- R12: conv_ce is high for one cycle in every CE_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 2 | Per-unit software start-bit set pulse |
| sw_halt | input | 2 | Per-unit start-bit clear (halt) pulse |
| dual_start | input | 1 | Shared dual-sampling start pulse |
| trg_sel | input | 2x4 | Per-unit hardware trigger select code |
| ch_sel | input | 2xCH_W | Per-unit channel field |
| run_mode | input | 2x2 | Per-unit mode: 0 single, 1 multi, 2 scan |
| ext_trg | input | 1 | External trigger request |
| tmr_a_trg | input | 1 | First timer conversion request |
| tmr_b_trg | input | 1 | Second timer conversion request |
| conv_done | input | 2 | Converter core finished the current conversion |
| conv_ce | output | 1 | Divided conversion clock enable |
| busy | output | 2 | Start bit per unit |
| smp_win | output | 2 | Sampling window per unit |
| conv_go | output | 2 | Conversion-start strobe per unit |
| cur_ch | output | 2xCH_W | Channel being sampled or converted |
| done | output | 2 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with CE_DIV of 5, SMP_CYC of 6, NEXT_CYC of 3 and the default START_LAT of 2. With the short window and an odd divider, a complete multi-channel or scan run finishes in a few dozen cycles, and start requests fall at many phases of the conversion clock enable, so the alignment delay is seen across its range. With a 3-cycle gap, the second and later conversions of a run are clearly shorter than the first and cannot be mistaken for it.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
   localparam int NUM_UNITS = 2;

   localparam logic [3:0] TRG_EXT = 4'd1;
   localparam logic [3:0] TRG_TMA = 4'd2;
   localparam logic [3:0] TRG_TMB = 4'd3;

   localparam logic [1:0] MODE_MULTI = 2'd1;
   localparam logic [1:0] MODE_SCAN  = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_LAT,
      ST_SAMPLE,
      ST_CONV,
      ST_GAP
   } seq_state_t;
endpackage

// File: rtl/adc_ce_div.sv
module adc_ce_div #(
   parameter int CE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic ce
);
   generate
      if (CE_DIV == 1) begin : g_full_rate
         assign ce = 1'b1;
      end else begin : g_divided
         localparam int DW = $clog2(CE_DIV);
         localparam logic [DW-1:0] WRAP = DW'(CE_DIV - 1);
         logic [DW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (cnt == WRAP) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign ce = (cnt == WRAP);
      end
   endgenerate
endmodule

// File: rtl/adc_trg_edge.sv
module adc_trg_edge #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   output logic [N_SRC-1:0] rise
);
   logic [N_SRC-1:0] src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src;
   end
   assign rise = src & ~src_q;
endmodule

// File: rtl/adc_unit_seq.sv
module adc_unit_seq
   import adc_trig_pkg::*;
#(
   parameter int START_LAT = 2,
   parameter int SMP_CYC   = 16,
   parameter int NEXT_CYC  = 4,
   parameter int CH_W      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce,
   input  logic            go,
   input  logic            halt,
   input  logic [1:0]      mode,
   input  logic [CH_W-1:0] ch_sel,
   input  logic            conv_done,
   output logic            busy,
   output logic            smp_win,
   output logic            conv_go,
   output logic [CH_W-1:0] cur_ch,
   output logic            done
);
   localparam int MAX_A = (START_LAT > SMP_CYC) ? START_LAT : SMP_CYC;
   localparam int MAXC  = (MAX_A > NEXT_CYC) ? MAX_A : NEXT_CYC;
   localparam int CW    = $clog2(MAXC + 1);
   localparam logic [CW-1:0] LAT_LD = CW'(START_LAT - 1);
   localparam logic [CW-1:0] SMP_LD = CW'(SMP_CYC - 1);
   localparam logic [CW-1:0] GAP_LD = CW'(NEXT_CYC - 1);

   seq_state_t      state;
   logic [CW-1:0]   cnt;
   logic [CH_W-1:0] ch, last_ch;
   logic            seq_q, scan_q, done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         ch      <= '0;
         last_ch <= '0;
         seq_q   <= 1'b0;
         scan_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (halt) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: if (go) begin
                  state   <= ST_ALIGN;
                  seq_q   <= (mode == MODE_MULTI) || (mode == MODE_SCAN);
                  scan_q  <= (mode == MODE_SCAN);
                  last_ch <= ch_sel;
                  ch      <= ((mode == MODE_MULTI) || (mode == MODE_SCAN)) ? '0 : ch_sel;
               end
               ST_ALIGN: if (ce) begin
                  state <= ST_LAT;
                  cnt   <= LAT_LD;
               end
               ST_LAT: begin
                  if (cnt == '0) begin
                     state <= ST_SAMPLE;
                     cnt   <= SMP_LD;
                  end else cnt <= cnt - 1'b1;
               end
               ST_SAMPLE: begin
                  if (cnt == '0) state <= ST_CONV;
                  else           cnt   <= cnt - 1'b1;
               end
               ST_CONV: if (conv_done) begin
                  if (seq_q && (scan_q || (ch != last_ch))) begin
                     state <= ST_GAP;
                     cnt   <= GAP_LD;
                     ch    <= (ch == last_ch) ? '0 : ch + 1'b1;
                  end else begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
               ST_GAP: begin
                  if (cnt == '0) begin
                     state <= ST_SAMPLE;
                     cnt   <= SMP_LD;
                  end else cnt <= cnt - 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy    = (state != ST_IDLE);
   assign smp_win = (state == ST_SAMPLE);
   assign conv_go = (state == ST_SAMPLE) && (cnt == '0);
   assign cur_ch  = ch;
   assign done    = done_q;
endmodule

// File: rtl/adc_dual_start.sv
module adc_dual_start
   import adc_trig_pkg::*;
#(
   parameter int CE_DIV    = 4,
   parameter int START_LAT = 2,
   parameter int SMP_CYC   = 16,
   parameter int NEXT_CYC  = 4,
   parameter int CH_W      = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_UNITS-1:0]           sw_start,
   input  logic [NUM_UNITS-1:0]           sw_halt,
   input  logic                           dual_start,
   input  logic [NUM_UNITS-1:0][3:0]      trg_sel,
   input  logic [NUM_UNITS-1:0][CH_W-1:0] ch_sel,
   input  logic [NUM_UNITS-1:0][1:0]      run_mode,
   input  logic                           ext_trg,
   input  logic                           tmr_a_trg,
   input  logic                           tmr_b_trg,
   input  logic [NUM_UNITS-1:0]           conv_done,
   output logic                           conv_ce,
   output logic [NUM_UNITS-1:0]           busy,
   output logic [NUM_UNITS-1:0]           smp_win,
   output logic [NUM_UNITS-1:0]           conv_go,
   output logic [NUM_UNITS-1:0][CH_W-1:0] cur_ch,
   output logic [NUM_UNITS-1:0]           done
);
   generate
      if (CE_DIV < 1)    begin : g_bad_div  $error("CE_DIV must be at least 1");    end
      if (START_LAT < 1) begin : g_bad_lat  $error("START_LAT must be at least 1"); end
      if (SMP_CYC < 1)   begin : g_bad_smp  $error("SMP_CYC must be at least 1");   end
      if (NEXT_CYC < 1)  begin : g_bad_next $error("NEXT_CYC must be at least 1");  end
      if (CH_W < 1)      begin : g_bad_chw  $error("CH_W must be at least 1");      end
   endgenerate

   logic [2:0] rise;
   logic       dual_go;

   adc_ce_div #(.CE_DIV(CE_DIV)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (conv_ce)
   );

   adc_trg_edge #(.N_SRC(3)) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src   ({tmr_b_trg, tmr_a_trg, ext_trg}),
      .rise  (rise)
   );

   assign dual_go = dual_start && (busy == '0);

   generate
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
         logic hit;

         always_comb begin
            case (trg_sel[u])
               TRG_EXT: hit = rise[0];
               TRG_TMA: hit = rise[1];
               TRG_TMB: hit = rise[2];
               default: hit = 1'b0;
            endcase
         end

         adc_unit_seq #(
            .START_LAT (START_LAT),
            .SMP_CYC   (SMP_CYC),
            .NEXT_CYC  (NEXT_CYC),
            .CH_W      (CH_W)
         ) i_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .ce        (conv_ce),
            .go        (sw_start[u] | dual_go | hit),
            .halt      (sw_halt[u]),
            .mode      (run_mode[u]),
            .ch_sel    (ch_sel[u]),
            .conv_done (conv_done[u]),
            .busy      (busy[u]),
            .smp_win   (smp_win[u]),
            .conv_go   (conv_go[u]),
            .cur_ch    (cur_ch[u]),
            .done      (done[u])
         );
      end
   endgenerate
endmodule

// File: rtl/adc_dual_start_chk.sv
module adc_dual_start_chk
   import adc_trig_pkg::*;
#(
   parameter int CE_DIV = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_UNITS-1:0] sw_start,
   input logic [NUM_UNITS-1:0] sw_halt,
   input logic                 dual_start,
   input logic                 conv_ce,
   input logic [NUM_UNITS-1:0] busy,
   input logic [NUM_UNITS-1:0] smp_win,
   input logic [NUM_UNITS-1:0] conv_go,
   input logic [NUM_UNITS-1:0] done
);
   generate
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
         p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy[u] && !sw_halt[u] && sw_start[u]) |=> busy[u]);
         p_win_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            smp_win[u] |-> busy[u]);
         p_go_in_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
            conv_go[u] |-> smp_win[u]);
         p_win_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
            conv_go[u] |=> !smp_win[u]);
         p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
            sw_halt[u] |=> (!busy[u] && !done[u]));
         p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            done[u] |-> !busy[u]);
         p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            done[u] |=> !done[u]);
      end
      if (CE_DIV > 1) begin : g_ce
         p_ce_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
            conv_ce |=> !conv_ce);
      end
   endgenerate

   p_dual_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_start && (busy == '0) && (sw_halt == '0)) |=> (busy == '1));
endmodule

bind adc_dual_start adc_dual_start_chk #(.CE_DIV(CE_DIV)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_start   (sw_start),
   .sw_halt    (sw_halt),
   .dual_start (dual_start),
   .conv_ce    (conv_ce),
   .busy       (busy),
   .smp_win    (smp_win),
   .conv_go    (conv_go),
   .done       (done)
);

// File: tb/test_adc_dual_start.sv
`timescale 1ns/1ps
module test_adc_dual_start;
   localparam int DIV  = 5;
   localparam int LATC = 2;
   localparam int SPL  = 6;
   localparam int NXT  = 3;
   localparam int CHW  = 3;
   localparam int STUB = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic [1:0]      sw_start = '0, sw_halt = '0, conv_done = '0;
   logic            dual_start = 1'b0, ext_trg = 1'b0, tmr_a_trg = 1'b0, tmr_b_trg = 1'b0;
   logic [1:0][3:0] trg_sel = '0;
   logic [1:0][CHW-1:0] ch_sel = '0;
   logic [1:0][1:0] run_mode = '0;
   logic            conv_ce;
   logic [1:0]      busy, smp_win, conv_go, done;
   logic [1:0][CHW-1:0] cur_ch;

   adc_dual_start #(.CE_DIV(DIV), .START_LAT(LATC), .SMP_CYC(SPL), .NEXT_CYC(NXT), .CH_W(CHW)) i_adc_dual_start (
      .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_halt(sw_halt), .dual_start(dual_start),
      .trg_sel(trg_sel), .ch_sel(ch_sel), .run_mode(run_mode), .ext_trg(ext_trg),
      .tmr_a_trg(tmr_a_trg), .tmr_b_trg(tmr_b_trg), .conv_done(conv_done), .conv_ce(conv_ce),
      .busy(busy), .smp_win(smp_win), .conv_go(conv_go), .cur_ch(cur_ch), .done(done));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // Scoreboard: expected channel per conversion, one queue per unit
   int q0[$], q1[$];
   string ch_req[2];
   function automatic void push(input int u, input int v);
      if (u == 0) q0.push_back(v); else q1.push_back(v);
   endfunction
   function automatic int qsize(input int u);
      return (u == 0) ? q0.size() : q1.size();
   endfunction
   function automatic int pop(input int u);
      return (u == 0) ? q0.pop_front() : q1.pop_front();
   endfunction

   bit    done_en[2];
   bit    wait_ce[2];
   int    exp_smp[2], smp_at[2], exp_done_cyc[2], done_seen[2];
   int    done_at[2] = '{-1, -1};
   string smp_req[2];
   logic [1:0] busy_d = '0, smp_d = '0;

   // Converter stub: pulse conv_done STUB cycles after conv_go
   always @(posedge clk) begin
      #1;
      for (int u = 0; u < 2; u++) conv_done[u] = (cyc == done_at[u]);
   end

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         for (int u = 0; u < 2; u++) begin
            if (busy[u] && !busy_d[u]) begin
               wait_ce[u] = 1;
               smp_req[u] = "R3 start delay";
            end
            if (wait_ce[u] && conv_ce) begin
               exp_smp[u] = cyc + LATC + 1;
               wait_ce[u] = 0;
            end
            if (smp_win[u] && !smp_d[u]) begin
               chk(cyc == exp_smp[u], smp_req[u], cyc, exp_smp[u]);
               smp_at[u] = cyc;
            end
            if (conv_go[u]) begin
               chk(cyc == smp_at[u] + SPL - 1, "R4 window length", cyc, smp_at[u] + SPL - 1);
               if (qsize(u) == 0) chk(0, "R11 unexpected conversion", u, -1);
               else begin
                  int v;
                  v = pop(u);
                  chk(int'(cur_ch[u]) == v, ch_req[u], int'(cur_ch[u]), v);
               end
               done_at[u] = cyc + STUB;
            end
            if (conv_done[u]) begin
               if (qsize(u) > 0) begin
                  exp_smp[u] = cyc + NXT + 1;
                  smp_req[u] = "R9 gap before next window";
               end else if (done_en[u]) exp_done_cyc[u] = cyc + 1;
            end
            if (done[u]) begin
               done_seen[u]++;
               chk(done_en[u] && cyc == exp_done_cyc[u] && !busy[u], "R8 done pulse", cyc, exp_done_cyc[u]);
            end
         end
         busy_d = busy;
         smp_d  = smp_win;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_run(input int u, input logic [1:0] mode, input int ch, input string req);
      ch_sel[u]   = CHW'(ch);
      run_mode[u] = mode;
      ch_req[u]   = req;
      done_en[u]  = (mode != 2'd2);
      if (mode == 2'd1) for (int i = 0; i <= ch; i++) push(u, i);
      else if (mode == 2'd2) for (int k = 0; k < 2; k++) for (int i = 0; i <= ch; i++) push(u, i);
      else push(u, ch);
   endtask

   task automatic sw_go(input int u, input logic [1:0] mode, input int ch, input string req);
      expect_run(u, mode, ch, req);
      tick(); sw_start[u] = 1'b1;
      tick(); sw_start[u] = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy != 2'b00);
      repeat (STUB + 3) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
   end

   initial begin
      int t0, d0, d1;
      repeat (3) @(negedge clk);
      chk(busy == 0 && smp_win == 0 && conv_go == 0 && done == 0, "R1 outputs in reset", int'(busy), 0);
      tick(); rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && smp_win == 0 && conv_go == 0 && done == 0, "R1 outputs after reset", int'(busy), 0);

      // R12: enable period
      do @(negedge clk); while (!conv_ce);
      t0 = cyc;
      @(negedge clk);
      chk(!conv_ce, "R12 enable one cycle", int'(conv_ce), 0);
      do @(negedge clk); while (!conv_ce);
      chk(cyc - t0 == DIV, "R12 enable period", cyc - t0, DIV);

      // R8: software single conversion on unit 0
      d0 = done_seen[0];
      sw_go(0, 2'd0, 5, "R8 single channel");
      wait_idle();
      chk(done_seen[0] == d0 + 1, "R8 one done", done_seen[0], d0 + 1);

      // R2 / R11: timer A on unit 1, held high
      trg_sel[1] = 4'd2;
      expect_run(1, 2'd0, 3, "R2 timer channel");
      d1 = done_seen[1];
      tick(); tmr_a_trg = 1'b1;
      @(negedge clk);
      chk(busy[1] == 1'b0, "R2 not yet started", int'(busy[1]), 0);
      @(negedge clk);
      chk(busy[1] == 1'b1, "R2 hardware start", int'(busy[1]), 1);
      repeat (40) tick();
      @(negedge clk);
      chk(busy[1] == 1'b0 && qsize(1) == 0, "R11 held trigger starts once", int'(busy[1]), 0);
      chk(done_seen[1] == d1 + 1, "R8 one done after hw run", done_seen[1], d1 + 1);
      tick(); tmr_a_trg = 1'b0;

      // R2: code 0 and an unused code select nothing
      trg_sel[0] = 4'd0; trg_sel[1] = 4'd9;
      tick(); ext_trg = 1'b1; tmr_a_trg = 1'b1; tmr_b_trg = 1'b1;
      tick(); ext_trg = 1'b0; tmr_a_trg = 1'b0; tmr_b_trg = 1'b0;
      repeat (4) @(negedge clk);
      chk(busy == 2'b00, "R2 codes 0 and 9 ignored", int'(busy), 0);

      // R5: shared external trigger
      trg_sel[0] = 4'd1; trg_sel[1] = 4'd1;
      expect_run(0, 2'd0, 2, "R5 own channel unit0");
      expect_run(1, 2'd0, 6, "R5 own channel unit1");
      tick(); ext_trg = 1'b1;
      tick(); ext_trg = 1'b0;
      @(negedge clk);
      chk(busy == 2'b11, "R5 both started", int'(busy), 3);
      wait_idle();
      chk(smp_at[0] == smp_at[1], "R5 same sampling cycle", smp_at[1], smp_at[0]);

      // R11: trigger edge while busy is dropped
      trg_sel[0] = 4'd3; trg_sel[1] = 4'd0;
      sw_go(0, 2'd0, 4, "R11 channel");
      repeat (4) tick();
      tmr_b_trg = 1'b1;
      tick(); tmr_b_trg = 1'b0;
      wait_idle();
      repeat (10) @(negedge clk);
      chk(busy[0] == 1'b0 && qsize(0) == 0, "R11 busy edge dropped", int'(busy[0]), 0);

      // R6: dual start with both idle
      trg_sel[0] = 4'd0;
      expect_run(0, 2'd0, 1, "R6 channel unit0");
      expect_run(1, 2'd0, 7, "R6 channel unit1");
      tick(); dual_start = 1'b1;
      tick(); dual_start = 1'b0;
      wait_idle();
      chk(smp_at[0] == smp_at[1], "R6 same sampling cycle", smp_at[1], smp_at[0]);

      // R6: dual start while unit 0 busy is ignored
      d0 = done_seen[0];
      sw_go(0, 2'd0, 2, "R6 running channel");
      repeat (5) tick();
      dual_start = 1'b1;
      tick(); dual_start = 1'b0;
      @(negedge clk);
      chk(busy == 2'b01, "R6 dual ignored when busy", int'(busy), 1);
      wait_idle();
      chk(done_seen[0] == d0 + 1, "R6 running conversion completes", done_seen[0], d0 + 1);

      // R9: multi mode on unit 0
      d0 = done_seen[0];
      sw_go(0, 2'd1, 2, "R9 channel order");
      wait_idle();
      chk(done_seen[0] == d0 + 1 && qsize(0) == 0, "R9 all channels then done", done_seen[0], d0 + 1);

      // R10 / R7: scan on unit 1, halted after two loops
      d1 = done_seen[1];
      sw_go(1, 2'd2, 1, "R10 scan order");
      do @(negedge clk); while (qsize(1) > 0);
      chk(busy[1] == 1'b1, "R10 scan stays busy", int'(busy[1]), 1);
      tick(); sw_halt[1] = 1'b1;
      tick(); sw_halt[1] = 1'b0;
      @(negedge clk);
      chk(busy[1] == 1'b0, "R7 halt clears busy", int'(busy[1]), 0);
      repeat (10) @(negedge clk);
      chk(done_seen[1] == d1, "R10 no done in scan", done_seen[1], d1);

      // R7: halt during the sampling window
      d0 = done_seen[0];
      sw_go(0, 2'd0, 6, "R7 channel");
      do @(negedge clk); while (!smp_win[0]);
      tick(); sw_halt[0] = 1'b1;
      tick(); sw_halt[0] = 1'b0;
      @(negedge clk);
      chk(busy[0] == 1'b0 && smp_win[0] == 1'b0, "R7 halt in window", int'({busy[0], smp_win[0]}), 0);
      q0.delete();
      repeat (12) @(negedge clk);
      chk(done_seen[0] == d0 && busy[0] == 1'b0, "R7 no done after halt", done_seen[0], d0);

      summary();
   end
endmodule